// File: doc/BRIEF.md
# Compare Match Timer Channel

A single up-counting timer channel with a small register set that software reads and writes over a simple word bus. Software loads a compare value, picks a mode and the interrupt enable in the control word, then sets the run bit. From then on the counter advances once on every cycle where the external count-enable input (a prescaled tick from outside the block) is high.

When the counter equals the compare value on a counting cycle, the counter returns to zero and the sticky match flag is set. In one-shot mode the channel then stops and the run bit drops by itself. In free-running mode counting goes on from zero. A match against the all-ones compare value also sets a sticky overflow flag. An interrupt line is high while the match flag is set and interrupts are enabled.

Top module: `match_timer`

## Requirements
- R1: After reset the counter reads 0, the compare value reads all ones, the run bit, mode bit, interrupt enable and both flags read 0, and the interrupt output is 0.
- R2: The counter increases by exactly 1 on each clock edge where the run bit is 1 and the count-enable input is 1, and on no other edge (unless software writes it).
- R3: On a counting edge where the counter equals the compare value, the counter becomes 0 and the match flag (control word bit 2) becomes 1, so one period is compare+1 counting edges.
- R4: With the mode bit (control word bit 0) at 0, the match edge also clears the run bit; the counter then stays at 0 until software writes 1 to the run bit, after which counting restarts from 0.
- R5: With the mode bit at 1, the run bit stays 1 at a match and counting continues from 0.
- R6: The overflow flag (control word bit 3) is set on a match edge only when the compare value is all ones; matches at other compare values leave it at 0.
- R7: Each flag stays 1 until software writes 0 to its bit of the control word; writing 1 to a flag bit leaves it unchanged; if a match edge and a clearing write meet, the flag ends at 1.
- R8: The interrupt output equals the match flag ANDed with the interrupt-enable bit (control word bit 1).
- R9: Writing 0 to the run bit stops counting and the counter holds its present value.
- R10: Register map by word address: 0 holds the run bit in bit 0; 1 is the control word (bit 0 mode, bit 1 interrupt enable, bit 2 match flag, bit 3 overflow flag, other bits read 0); 2 is the compare value; 3 is the counter, writable while stopped. The read data shows the register at the current address without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Prescaled count enable |
| addr | input | 2 | Word address for read and write |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume software follows the usage rule that only flag clears happen while the channel runs: compare value and counter writes are expected only with the run bit at 0, so checks that look back at the compare value after an overflow are valid. The stimulus keeps to that rule, stopping the channel before loading a new compare or counter value, and holds count-enable low during register reads so that each read sees a settled value. The one deliberate overlap is a flag-clearing write on the very edge of a match, which the usage rule allows.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam logic [1:0] ADDR_RUN  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int BIT_MODE  = 0;
  localparam int BIT_IEN   = 1;
  localparam int BIT_MATCH = 2;
  localparam int BIT_OVF   = 3;
  localparam int CTRL_BITS = 4;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic cntLoad;
    logic cmpLoad;
  } dpStrobes_t;
endpackage

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cmp,
  output logic             isMatch,
  output logic             cmpFull
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      cmp <= ALL_ONES;
    end else begin
      if (strb.cmpLoad) cmp <= wrData;
      if (strb.cntLoad)     cnt <= wrData;
      else if (strb.cntClr) cnt <= '0;
      else if (strb.cntInc) cnt <= cnt + 1'b1;
    end
  end

  assign isMatch = (cnt == cmp);
  assign cmpFull = (cmp == ALL_ONES);
endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEn,
  input  logic                 wrEn,
  input  logic [1:0]           addr,
  input  logic [CTRL_BITS-1:0] wrBits,
  input  logic                 isMatch,
  input  logic                 cmpFull,
  output dpStrobes_t           strb,
  output logic                 run,
  output logic                 freeRun,
  output logic                 irqEn,
  output logic                 matchFlag,
  output logic                 ovfFlag
);
  logic wrRun, wrCtrl, tick, wrap;

  assign wrRun  = wrEn && (addr == ADDR_RUN);
  assign wrCtrl = wrEn && (addr == ADDR_CTRL);

  always_comb begin
    strb.cntLoad = wrEn && (addr == ADDR_CNT);
    strb.cmpLoad = wrEn && (addr == ADDR_CMP);
    tick         = run && cntEn && !strb.cntLoad;
    wrap         = tick && isMatch;
    strb.cntClr  = wrap;
    strb.cntInc  = tick && !isMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run       <= 1'b0;
      freeRun   <= 1'b0;
      irqEn     <= 1'b0;
      matchFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (wrRun)                 run <= wrBits[0];
      else if (wrap && !freeRun) run <= 1'b0;

      if (wrCtrl) begin
        freeRun <= wrBits[BIT_MODE];
        irqEn   <= wrBits[BIT_IEN];
      end

      if (wrap)                         matchFlag <= 1'b1;
      else if (wrCtrl && !wrBits[BIT_MATCH]) matchFlag <= 1'b0;

      if (wrap && cmpFull)              ovfFlag <= 1'b1;
      else if (wrCtrl && !wrBits[BIT_OVF])   ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [1:0]       addr,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             irq
);
  dpStrobes_t       strb;
  logic [WIDTH-1:0] cnt, cmp;
  logic             isMatch, cmpFull;
  logic             run, freeRun, irqEn, matchFlag, ovfFlag;

  match_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .addr(addr),
    .wrBits(wrData[CTRL_BITS-1:0]), .isMatch(isMatch), .cmpFull(cmpFull),
    .strb(strb), .run(run), .freeRun(freeRun), .irqEn(irqEn),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  match_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .cmp(cmp), .isMatch(isMatch), .cmpFull(cmpFull)
  );

  always_comb begin
    unique case (addr)
      ADDR_RUN:  rdData = {{(WIDTH-1){1'b0}}, run};
      ADDR_CTRL: rdData = {{(WIDTH-CTRL_BITS){1'b0}}, ovfFlag, matchFlag, irqEn, freeRun};
      ADDR_CMP:  rdData = cmp;
      default:   rdData = cnt;
    endcase
  end

  assign irq = matchFlag && irqEn;
endmodule

// File: rtl/match_timer_checker.sv
module match_timer_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic             wrMatchBit,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] cmp,
  input logic             run,
  input logic             freeRun,
  input logic             irqEn,
  input logic             matchFlag,
  input logic             ovfFlag,
  input logic             irq
);
  logic cntWr, runWr, ctrlWr, hitEdge;
  assign cntWr   = wrEn && (addr == 2'd3);
  assign runWr   = wrEn && (addr == 2'd0);
  assign ctrlWr  = wrEn && (addr == 2'd1);
  assign hitEdge = run && cntEn && !cntWr && (cnt == cmp);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    run && cntEn && !cntWr && (cnt != cmp) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    hitEdge |=> (cnt == '0) && matchFlag);

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitEdge && !freeRun && !runWr |=> !run);

  p_freerun_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitEdge && freeRun && !runWr |=> run);

  p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> matchFlag && ($past(cmp) == {WIDTH{1'b1}}));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !(ctrlWr && !wrMatchBit) |=> matchFlag);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> matchFlag && irqEn);

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rstN)
    !run && !cntWr |=> $stable(cnt));
endmodule

bind match_timer match_timer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .addr(addr),
  .wrMatchBit(wrData[2]), .cnt(cnt), .cmp(cmp), .run(run),
  .freeRun(freeRun), .irqEn(irqEn), .matchFlag(matchFlag),
  .ovfFlag(ovfFlag), .irq(irq)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;   // 0..3 register address, 4 = irq pin
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.sel == 4) ? {31'd0, irq} : rdData;
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input int sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (sel < 4) addr = sel[1:0];
    sb.push_back('{sel, exp, tag});
    #2;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R10 map
    expect_reg(3, 32'd0, "R1 counter");
    expect_reg(2, 32'hFFFF_FFFF, "R1 compare");
    expect_reg(0, 32'd0, "R1 run");
    expect_reg(1, 32'd0, "R1 control");
    expect_reg(4, 32'd0, "R1 irq");

    // R2: no counting while stopped, or while enable is low
    write_reg(2'd2, 32'd10);
    expect_reg(2, 32'd10, "R10 compare write");
    ticks(5);
    expect_reg(3, 32'd0, "R2 stopped no count");
    write_reg(2'd0, 32'd1);
    repeat (4) @(negedge clk);
    expect_reg(3, 32'd0, "R2 enable low no count");
    ticks(3);
    expect_reg(3, 32'd3, "R2 three ticks");

    // R9 stop holds value
    write_reg(2'd0, 32'd0);
    ticks(4);
    expect_reg(3, 32'd3, "R9 hold while stopped");
    write_reg(2'd0, 32'd1);
    ticks(7);
    expect_reg(3, 32'd10, "R3 equal to compare before match edge");
    expect_reg(1, 32'd0, "R3 no flag before match edge");
    ticks(1);
    expect_reg(3, 32'd0, "R3 cleared at match");
    expect_reg(1, 32'd4, "R3 match flag set, R6 no overflow");
    expect_reg(0, 32'd0, "R4 one-shot clears run");
    ticks(3);
    expect_reg(3, 32'd0, "R4 halted after match");

    // R7 write 1 keeps, write 0 clears
    write_reg(2'd1, 32'd4);
    expect_reg(1, 32'd4, "R7 write one keeps flag");
    write_reg(2'd1, 32'd0);
    expect_reg(1, 32'd0, "R7 write zero clears flag");

    // R5 free-running with R8 interrupt
    write_reg(2'd1, 32'd3);
    expect_reg(4, 32'd0, "R8 irq low without flag");
    write_reg(2'd2, 32'd4);
    write_reg(2'd0, 32'd1);
    ticks(5);
    expect_reg(3, 32'd0, "R5 wrap to zero");
    expect_reg(0, 32'd1, "R5 run stays set");
    expect_reg(1, 32'd7, "R5 flag set in free-run");
    expect_reg(4, 32'd1, "R8 irq high");
    ticks(2);
    expect_reg(3, 32'd2, "R5 counts on after wrap");

    // R7 set wins over a clear on the same edge
    ticks(2);
    expect_reg(3, 32'd4, "R7 setup at compare");
    @(negedge clk);
    addr = 2'd1; wrData = 32'd3; wrEn = 1'b1; cntEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cntEn = 1'b0;
    expect_reg(1, 32'd7, "R7 set beats clear");
    expect_reg(3, 32'd0, "R3 wrap during write");
    write_reg(2'd1, 32'd3);
    expect_reg(4, 32'd0, "R8 irq low after clear");
    write_reg(2'd1, 32'd0);
    write_reg(2'd1, 32'd4 | 32'd0);
    expect_reg(4, 32'd0, "R8 irq low with enable off");

    // R6 overflow at all-ones compare
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, 32'd0);
    write_reg(2'd2, 32'hFFFF_FFFF);
    write_reg(2'd3, 32'hFFFF_FFFD);
    expect_reg(3, 32'hFFFF_FFFD, "R10 counter write");
    write_reg(2'd0, 32'd1);
    ticks(2);
    expect_reg(3, 32'hFFFF_FFFF, "R6 at all ones");
    expect_reg(1, 32'd0, "R6 no flags yet");
    ticks(1);
    expect_reg(3, 32'd0, "R6 wrap to zero");
    expect_reg(1, 32'd12, "R6 match and overflow");
    expect_reg(0, 32'd0, "R4 one-shot stop on overflow");
    write_reg(2'd1, 32'd4);
    expect_reg(1, 32'd4, "R7 overflow cleared alone");

    // R4 restart from zero
    write_reg(2'd0, 32'd1);
    ticks(3);
    expect_reg(3, 32'd3, "R4 restart counts from zero");
    expect_reg(0, 32'd1, "R4 run set after restart");

    wait (sb.size() == 0);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule